// File: doc/BRIEF.md
# SGRAM Power-Up and Mode-Set Sequencer

This block takes a two-bank synchronous graphics DRAM from reset to a usable state. It drives only the command side of the device: chip select, row strobe, column strobe, write enable, clock enable, the four byte masks, an 11-bit address bus and the bank select. First it keeps the device quiet for a settle interval measured in clock cycles. Then it closes every bank, waits the row-precharge time and issues a train of auto-refresh commands. Last it programs the mode register from configuration pins and signals readiness.

The settle interval is given in nanoseconds together with the clock period, and the cycle count is derived from them. The precharge gap, refresh cycle gap and mode-set recovery gap are cycle-count parameters. Each must be at least 2. The refresh count is a parameter; values below 8 are raised to 8. The configuration pins are plain levels, with no handshake. When they hold a reserved code at the point where the mode word would be written, the sequencer flags an error and waits with NOP. It writes the mode register in the first cycle the pins become legal.

Command encoding on {cs_n, ras_n, cas_n, we_n}: NOP = 0111, precharge = 0010, auto-refresh = 0001, mode-register set = 0000.

Top module: `sgram_init_seq`

## Requirements
- R1: cke is 1 and dqm is 4'hF at all times, and for the first SETTLE cycles after reset (SETTLE = ceil(SETTLE_NS / CLK_PERIOD_NS)) only NOP (0111) is presented.
- R2: The first command, in cycle SETTLE after reset, is precharge-all: code 0010 with addr[10] = 1 and all other address bits 0.
- R3: The first auto-refresh follows the precharge by exactly T_RP cycles.
- R4: Exactly REFRESH_COUNT auto-refresh commands (code 0001, address 0) are issued, each T_RC cycles after the previous one.
- R5: With a legal configuration, the mode-register set (code 0000, ba = 0) comes T_RC cycles after the last refresh. Its address is {1'b0, mode[2:0] on addr[9:7], cas_lat on addr[6:4], burst_type on addr[3], burst_len on addr[2:0]}, and no command follows it.
- R6: Burst-length codes 000, 001, 010 and 011 are legal. Code 111 is legal only with burst_type 0. Every other code is reserved.
- R7: CAS-latency codes 010 and 011 are legal; every other code is reserved.
- R8: Operating-mode codes 000 and 010 are legal; every other code is reserved.
- R9: If any field is reserved when the mode set is due, cfg_error is 1 and only NOP is issued. In the first cycle all fields are legal, the mode set is issued in that same cycle and cfg_error returns to 0.
- R10: ready rises exactly T_RSC cycles after the mode-register set and stays 1. Only NOP is issued after that.
- R11: A synchronous reset returns the block to the start of the settle phase: the next cycle shows NOP, ready = 0, cfg_error = 0, and the whole sequence restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_burst_len | input | 3 | Burst-length code |
| cfg_burst_type | input | 1 | 0 sequential, 1 interleaved |
| cfg_cas_lat | input | 3 | CAS-latency code |
| cfg_op_mode | input | 3 | Operating-mode code |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| cke | output | 1 | Clock enable |
| dqm | output | 4 | Byte masks |
| addr | output | 11 | Address bus |
| ba | output | 1 | Bank select |
| ready | output | 1 | Initialization complete |
| cfg_error | output | 1 | Reserved configuration while waiting to set mode |

## Verification
Almost every internal fault shows up as a command at the wrong cycle. A timer that is off by one moves the precharge, a refresh or the mode set by one cycle, and the scoreboard notices it at that command's expected cycle. A refresh counter with the wrong limit changes the number of refresh commands: an extra one, or a mode set that arrives one refresh gap early. A wrong legality decode shows up either as a mode set during the stall or as cfg_error in the cycle the mode set is due. A wrong mode-word layout is seen in the address compare of that single command.

// File: rtl/sgi_pkg.sv
package sgi_pkg;
  typedef enum logic [3:0] {
    CMD_MRS  = 4'b0000,
    CMD_REF  = 4'b0001,
    CMD_PREA = 4'b0010,
    CMD_NOP  = 4'b0111
  } sgi_cmd_e;

  typedef enum logic [2:0] {
    ST_SETTLE,
    ST_PREA,
    ST_WAIT_RP,
    ST_REF,
    ST_WAIT_RC,
    ST_MODE,
    ST_WAIT_RSC,
    ST_READY
  } sgi_state_e;

  localparam int ADDR_W = 11;
endpackage

// File: rtl/sgi_mode_check.sv
module sgi_mode_check
  import sgi_pkg::*;
(
  input  logic [2:0]        burst_len,
  input  logic              burst_type,
  input  logic [2:0]        cas_lat,
  input  logic [2:0]        op_mode,
  output logic [ADDR_W-1:0] word,
  output logic              legal
);
  logic bl_ok, cl_ok, op_ok;

  always_comb begin
    unique case (burst_len)
      3'b000, 3'b001, 3'b010, 3'b011: bl_ok = 1'b1;
      3'b111:                         bl_ok = ~burst_type;
      default:                        bl_ok = 1'b0;
    endcase
    cl_ok = (cas_lat == 3'b010) || (cas_lat == 3'b011);
    op_ok = (op_mode == 3'b000) || (op_mode == 3'b010);
  end

  assign legal = bl_ok & cl_ok & op_ok;
  assign word  = {1'b0, op_mode, cas_lat, burst_type, burst_len};
endmodule

// File: rtl/sgi_gap_timer.sv
module sgi_gap_timer #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= RST_VAL;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - W'(1);
  end

  assign done = (cnt == '0);

  // R3: an expired gap stays expired until reloaded
  a_r3_hold_at_zero: assert property (@(posedge clk) disable iff (rst)
    (!load && done) |=> done);
  // R3: a running gap shrinks by exactly one per cycle
  a_r3_count_down: assert property (@(posedge clk) disable iff (rst)
    (!load && !done) |=> (cnt == $past(cnt) - W'(1)));
endmodule

// File: rtl/sgi_pin_drive.sv
module sgi_pin_drive
  import sgi_pkg::*;
(
  input  sgi_cmd_e          cmd,
  input  logic [ADDR_W-1:0] mode_word,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              cke,
  output logic [3:0]        dqm,
  output logic [ADDR_W-1:0] addr,
  output logic              ba
);
  always_comb begin
    {cs_n, ras_n, cas_n, we_n} = cmd;
    cke = 1'b1;
    dqm = 4'hF;
    ba  = 1'b0;
    unique case (cmd)
      CMD_PREA: addr = ADDR_W'(1) << 10;
      CMD_MRS:  addr = mode_word;
      default:  addr = '0;
    endcase
  end
endmodule

// File: rtl/sgram_init_seq.sv
module sgram_init_seq
  import sgi_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 20,
  parameter int SETTLE_NS     = 500000,
  parameter int T_RP          = 3,
  parameter int T_RC          = 7,
  parameter int T_RSC         = 2,
  parameter int REFRESH_COUNT = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  cfg_burst_len,
  input  logic        cfg_burst_type,
  input  logic [2:0]  cfg_cas_lat,
  input  logic [2:0]  cfg_op_mode,
  output logic        cs_n,
  output logic        ras_n,
  output logic        cas_n,
  output logic        we_n,
  output logic        cke,
  output logic [3:0]  dqm,
  output logic [10:0] addr,
  output logic        ba,
  output logic        ready,
  output logic        cfg_error
);
  localparam int SETTLE_CYC = (SETTLE_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
  localparam int NREF       = (REFRESH_COUNT < 8) ? 8 : REFRESH_COUNT;
  localparam int GAP_A      = (T_RP > T_RC) ? T_RP : T_RC;
  localparam int GAP_B      = (GAP_A > T_RSC) ? GAP_A : T_RSC;
  localparam int MAXGAP     = (SETTLE_CYC > GAP_B) ? SETTLE_CYC : GAP_B;
  localparam int TW         = $clog2(MAXGAP + 1);
  localparam int RW         = $clog2(NREF + 1);

  sgi_state_e        state, state_nx;
  logic [RW-1:0]     ref_cnt;
  logic              t_load, t_done;
  logic [TW-1:0]     t_val;
  logic              cfg_legal;
  logic [ADDR_W-1:0] mode_word;
  sgi_cmd_e          cmd;

  sgi_mode_check u_check (
    .burst_len (cfg_burst_len),
    .burst_type(cfg_burst_type),
    .cas_lat   (cfg_cas_lat),
    .op_mode   (cfg_op_mode),
    .word      (mode_word),
    .legal     (cfg_legal)
  );

  sgi_gap_timer #(.W(TW), .RST_VAL(TW'(SETTLE_CYC - 1))) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (t_load),
    .load_val(t_val),
    .done    (t_done)
  );

  always_comb begin
    state_nx = state;
    t_load   = 1'b0;
    t_val    = '0;
    unique case (state)
      ST_SETTLE:   if (t_done) state_nx = ST_PREA;
      ST_PREA: begin
        t_load   = 1'b1;
        t_val    = TW'(T_RP - 2);
        state_nx = ST_WAIT_RP;
      end
      ST_WAIT_RP:  if (t_done) state_nx = ST_REF;
      ST_REF: begin
        t_load   = 1'b1;
        t_val    = TW'(T_RC - 2);
        state_nx = ST_WAIT_RC;
      end
      ST_WAIT_RC:
        if (t_done) state_nx = (ref_cnt == RW'(NREF)) ? ST_MODE : ST_REF;
      ST_MODE:
        if (cfg_legal) begin
          t_load   = 1'b1;
          t_val    = TW'(T_RSC - 2);
          state_nx = ST_WAIT_RSC;
        end
      ST_WAIT_RSC: if (t_done) state_nx = ST_READY;
      default:     state_nx = ST_READY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_SETTLE;
      ref_cnt <= '0;
    end else begin
      state <= state_nx;
      if (state == ST_REF) ref_cnt <= ref_cnt + RW'(1);
    end
  end

  always_comb begin
    unique case (state)
      ST_PREA: cmd = CMD_PREA;
      ST_REF:  cmd = CMD_REF;
      ST_MODE: cmd = cfg_legal ? CMD_MRS : CMD_NOP;
      default: cmd = CMD_NOP;
    endcase
  end

  sgi_pin_drive u_pins (
    .cmd      (cmd),
    .mode_word(mode_word),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .cke      (cke),
    .dqm      (dqm),
    .addr     (addr),
    .ba       (ba)
  );

  assign ready     = (state == ST_READY);
  assign cfg_error = (state == ST_MODE) && !cfg_legal;

  a_r1_settle_quiet: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SETTLE) |-> ({cs_n, ras_n, cas_n, we_n} == 4'b0111 && cke && dqm == 4'hF));
  a_r2_prea_a10: assert property (@(posedge clk) disable iff (rst)
    ({cs_n, ras_n, cas_n, we_n} == 4'b0010) |-> addr[10]);
  a_r4_ref_bound: assert property (@(posedge clk) disable iff (rst)
    ref_cnt <= RW'(NREF));
  a_r5_mrs_legal: assert property (@(posedge clk) disable iff (rst)
    ({cs_n, ras_n, cas_n, we_n} == 4'b0000) |-> (cfg_legal && !ba && !addr[10]));
  a_r9_stall_quiet: assert property (@(posedge clk) disable iff (rst)
    cfg_error |-> ({cs_n, ras_n, cas_n, we_n} == 4'b0111 && !ready));
  a_r10_ready_sticky: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);
  a_r11_reset_clears: assert property (@(posedge clk)
    rst |=> (!ready && !cfg_error && {cs_n, ras_n, cas_n, we_n} == 4'b0111));
endmodule

// File: tb/sgram_init_seq_test.sv
module sgram_init_seq_test;
  localparam int CLK_NS    = 20;
  localparam int SETTLE_NS = 2000;
  localparam int T_RP      = 3;
  localparam int T_RC      = 5;
  localparam int T_RSC     = 3;
  localparam int NREF      = 9;
  localparam int S         = (SETTLE_NS + CLK_NS - 1) / CLK_NS;
  localparam int M         = S + T_RP + NREF * T_RC;
  localparam logic [3:0] NOP = 4'b0111, PREA = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

  logic clk = 1'b0, rst = 1'b1;
  logic [2:0] bl = 3'b010, cl = 3'b011, op = 3'b000;
  logic bt = 1'b0;
  logic cs_n, ras_n, cas_n, we_n, cke, ba, ready, cfg_error;
  logic [3:0] dqm;
  logic [10:0] addr;

  always #(CLK_NS / 2) clk = ~clk;

  sgram_init_seq #(
    .CLK_PERIOD_NS(CLK_NS), .SETTLE_NS(SETTLE_NS), .T_RP(T_RP),
    .T_RC(T_RC), .T_RSC(T_RSC), .REFRESH_COUNT(NREF)
  ) uut (
    .clk(clk), .rst(rst), .cfg_burst_len(bl), .cfg_burst_type(bt),
    .cfg_cas_lat(cl), .cfg_op_mode(op), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .cke(cke), .dqm(dqm), .addr(addr),
    .ba(ba), .ready(ready), .cfg_error(cfg_error)
  );

  typedef struct packed {
    int          cyc;
    logic [3:0]  cmd;
    logic [10:0] addr;
  } exp_t;

  exp_t  expq[$];
  int    checks = 0, fails = 0, cyc = 0;
  int    err_from = 0, err_to = 0, rdy_at = 1000000;
  logic  rs_edge = 1'b0;
  string scen = "R5";

  always @(posedge clk) begin
    rs_edge <= rst;
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", req, what, cyc, act, exp);
    end
  endtask

  // monitor: pops expected commands and compares them with the pins
  always @(negedge clk) begin
    logic [3:0] pc;
    exp_t e;
    string tag;
    pc = {cs_n, ras_n, cas_n, we_n};
    if (rs_edge) begin
      check(pc == NOP && !ready && !cfg_error, "R11", "reset state {cmd,ready,err}",
            {pc, 2'b00, ready, cfg_error}, {NOP, 4'b0000});
    end else if (!rst) begin
      check(cke && dqm == 4'hF, "R1", "cke/dqm", {cke, dqm}, 5'h1F);
      if (cyc < S) check(pc == NOP, "R1", "settle command", pc, NOP);
      check(ready == (cyc >= rdy_at), "R10", "ready", ready, cyc >= rdy_at);
      check(cfg_error == (cyc >= err_from && cyc < err_to), scen, "cfg_error (R9)",
            cfg_error, cyc >= err_from && cyc < err_to);
      if (pc != NOP) begin
        if (expq.size() == 0) begin
          check(1'b0, "R10", "unexpected command", pc, NOP);
        end else begin
          e = expq.pop_front();
          tag = (e.cmd == PREA) ? "R2" : (e.cmd == REF) ? "R4" : scen;
          check(cyc == e.cyc, (e.cmd == REF) ? "R3/R4" : tag, "command cycle", cyc, e.cyc);
          check(pc == e.cmd, tag, "command code", pc, e.cmd);
          check(addr == e.addr && !ba, tag, "address/bank", {ba, addr}, e.addr);
        end
      end
    end
  end

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  // driver: resets, sets the config and pushes the expected command train
  task automatic run(input logic [2:0] ibl, input logic ibt, input logic [2:0] icl,
                     input logic [2:0] iop, input int hold,
                     input logic [2:0] fbl, input logic fbt, input logic [2:0] fcl,
                     input logic [2:0] fop, input int abort_at, input string req);
    int mrs;
    step();
    rst = 1'b1;
    bl = ibl; bt = ibt; cl = icl; op = iop;
    scen = req;
    expq.delete();
    mrs = M + hold;
    expq.push_back('{S, PREA, 11'h400});
    for (int i = 0; i < NREF; i++) expq.push_back('{S + T_RP + i * T_RC, REF, 11'h000});
    expq.push_back('{mrs, MRS, {1'b0, fop, fcl, fbt, fbl}});
    err_from = (hold > 0) ? M : 0;
    err_to   = (hold > 0) ? mrs : 0;
    rdy_at   = mrs + T_RSC;
    step();
    step();
    rst = 1'b0;
    if (abort_at > 0) begin
      while (cyc < abort_at) step();
      return;
    end
    if (hold > 0) begin
      while (cyc < mrs) step();
      bl = fbl; bt = fbt; cl = fcl; op = fop;
    end
    while (cyc < rdy_at + 6) step();
    check(expq.size() == 0, req, "commands left unseen (R5)", expq.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R10", "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    // R5: legal burst 4, sequential, latency 3, normal mode
    run(3'b010, 1'b0, 3'b011, 3'b000, 0, 3'b010, 1'b0, 3'b011, 3'b000, 0, "R5");
    // R11: reset in the middle of the refresh train, then restart
    run(3'b001, 1'b1, 3'b010, 3'b000, 0, 3'b001, 1'b1, 3'b010, 3'b000,
        S + T_RP + 2 * T_RC + 1, "R11");
    // R5/R8: full page sequential, latency 2, burst read with single write
    run(3'b111, 1'b0, 3'b010, 3'b010, 0, 3'b111, 1'b0, 3'b010, 3'b010, 0, "R8");
    // R6: full page with interleaved type is reserved; fix to burst 8 interleaved
    run(3'b111, 1'b1, 3'b011, 3'b000, 15, 3'b011, 1'b1, 3'b011, 3'b000, 0, "R6");
    // R6: burst-length code 100 is reserved; fix to 000
    run(3'b100, 1'b0, 3'b010, 3'b000, 7, 3'b000, 1'b0, 3'b010, 3'b000, 0, "R6");
    // R7: latency code 001 is reserved; fix to 010
    run(3'b011, 1'b0, 3'b001, 3'b000, 11, 3'b011, 1'b0, 3'b010, 3'b000, 0, "R7");
    // R8: mode code 011 is reserved; fix to 010
    run(3'b000, 1'b1, 3'b011, 3'b011, 4, 3'b000, 1'b1, 3'b011, 3'b010, 0, "R8");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule